// File: doc/BRIEF.md
# Response Frame Transmit Scheduler

This block sequences a single "fire and forget" transmission from a wireless MAC, such as a clear-to-send or acknowledgement reply. Software loads a packet buffer index, an antenna mask, a NAV requirement bit and three wait-select bits, then pulses an enable bit. The rising edge of that bit captures the configuration and starts the machine.

If no wait-select is set, the machine goes straight to the transmit decision. Otherwise it holds until every selected external interval timer reports done. The choice is among post-receive timer 1, post-receive timer 2 and post-transmit timer 1. At the transmit decision the machine looks at the NAV. If the NAV is non-zero and the NAV requirement bit was captured as 1, the frame is dropped and a cancel pulse is raised. If not, the machine sends a one-cycle start pulse to the PHY carrying the captured buffer index and antenna mask. It then waits for the PHY to report completion, raises a done pulse and returns to idle. No backoff, medium sensing or post-transmit timeout takes part.

Top module: `resp_tx_sched`

## Requirements
- R1: While rst_ni is low the machine is idle and phy_start_o, done_o and cancel_o are 0. A reset during a wait discards the pending transmission.
- R2: Only a 0-to-1 change of start_en_i starts the machine. Holding start_en_i at 1 starts nothing further.
- R3: With all three wait-select bits 0, phy_start_o is 1 in the second cycle after the cycle in which start_en_i rises. This is counted in rising clock edges: edge 1 captures the request and edge 2 raises the pulse.
- R4: With wait-selects set, the machine waits until all selected timer-done inputs are 1 in the same cycle. Unselected timer-done inputs are ignored. phy_start_o rises two edges after that cycle.
- R5: phy_buf_o and phy_ant_o carry the values of cfg_buf_i and cfg_ant_i captured at the starting edge. Later changes of the configuration inputs have no effect on them.
- R6: If cfg_nav_req_i was captured as 1 and nav_busy_i is 1 at the transmit decision, cancel_o pulses for one cycle in place of phy_start_o. The machine then returns to idle.
- R7: If cfg_nav_req_i was captured as 0, the value of nav_busy_i has no effect and the frame is sent.
- R8: After phy_start_o, done_o pulses for one cycle on the edge after phy_done_i is seen high. The machine is then idle and ready for a new start.
- R9: A rising edge of start_en_i while the machine is not idle is ignored.
- R10: phy_start_o, done_o and cancel_o are each single-cycle pulses. done_o and cancel_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_en_i | input | 1 | Software enable bit; its rising edge starts the machine |
| cfg_buf_i | input | BUF_W | Packet buffer index |
| cfg_ant_i | input | ANT_W | Antenna mask |
| cfg_nav_req_i | input | 1 | Require a zero NAV at transmit time |
| cfg_wait_rx1_i | input | 1 | Wait for post-receive timer 1 |
| cfg_wait_rx2_i | input | 1 | Wait for post-receive timer 2 |
| cfg_wait_tx1_i | input | 1 | Wait for post-transmit timer 1 |
| rx1_done_i | input | 1 | Post-receive timer 1 expired |
| rx2_done_i | input | 1 | Post-receive timer 2 expired |
| tx1_done_i | input | 1 | Post-transmit timer 1 expired |
| nav_busy_i | input | 1 | NAV counter is non-zero |
| phy_done_i | input | 1 | PHY finished transmitting |
| phy_start_o | output | 1 | One-cycle transmit start to the PHY |
| phy_buf_o | output | BUF_W | Captured buffer index |
| phy_ant_o | output | ANT_W | Captured antenna mask |
| done_o | output | 1 | Transmission completed |
| cancel_o | output | 1 | Transmission dropped by the NAV check |

## Verification
A state register stuck outside idle shows up at the ports as a start that never produces phy_start_o, or as a fresh enable edge that is lost. Both are visible two cycles after the edge. A wrong wait decode shows as phy_start_o rising while a selected timer is still low, or never rising once all selected timers are high. Each bench transaction checks the exact cycle. A lost NAV decision shows as phy_start_o in the cycle where cancel_o was expected, or the reverse.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
  localparam int unsigned NUM_WAIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DECIDE = 2'd2,
    ST_BUSY = 2'd3
  } sched_state_e;
endpackage

// File: rtl/resp_tx_edge.sv
module resp_tx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/resp_tx_wait_gate.sv
module resp_tx_wait_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] done_i,
  output logic         any_sel_o,
  output logic         ready_o
);
  logic [N-1:0] ok;

  for (genvar g = 0; g < N; g++) begin : g_tmr
    assign ok[g] = done_i[g] | ~sel_i[g];
  end

  assign ready_o   = &ok;
  assign any_sel_o = |sel_i;
endmodule

// File: rtl/resp_tx_fsm.sv
module resp_tx_fsm
  import resp_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic new_tx_i,
  input  logic any_wait_i,
  input  logic ready_i,
  input  logic nav_req_i,
  input  logic nav_busy_i,
  input  logic phy_done_i,
  output logic idle_o,
  output logic phy_start_o,
  output logic done_o,
  output logic cancel_o
);
  sched_state_e st_q, st_d;
  logic start_d, done_d, cancel_d;

  always_comb begin
    st_d     = st_q;
    start_d  = 1'b0;
    done_d   = 1'b0;
    cancel_d = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (new_tx_i) st_d = any_wait_i ? ST_WAIT : ST_DECIDE;
      ST_WAIT:   if (ready_i) st_d = ST_DECIDE;
      ST_DECIDE: begin
        if (nav_req_i && nav_busy_i) begin
          cancel_d = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          start_d  = 1'b1;
          st_d     = ST_BUSY;
        end
      end
      ST_BUSY:   if (phy_done_i) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      phy_start_o <= 1'b0;
      done_o      <= 1'b0;
      cancel_o    <= 1'b0;
    end else begin
      st_q        <= st_d;
      phy_start_o <= start_d;
      done_o      <= done_d;
      cancel_o    <= cancel_d;
    end
  end

  assign idle_o = (st_q == ST_IDLE);
endmodule

// File: rtl/resp_tx_sched.sv
module resp_tx_sched
  import resp_tx_pkg::*;
#(
  parameter int unsigned BUF_W = 4,
  parameter int unsigned ANT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_en_i,
  input  logic [BUF_W-1:0] cfg_buf_i,
  input  logic [ANT_W-1:0] cfg_ant_i,
  input  logic             cfg_nav_req_i,
  input  logic             cfg_wait_rx1_i,
  input  logic             cfg_wait_rx2_i,
  input  logic             cfg_wait_tx1_i,
  input  logic             rx1_done_i,
  input  logic             rx2_done_i,
  input  logic             tx1_done_i,
  input  logic             nav_busy_i,
  input  logic             phy_done_i,
  output logic             phy_start_o,
  output logic [BUF_W-1:0] phy_buf_o,
  output logic [ANT_W-1:0] phy_ant_o,
  output logic             done_o,
  output logic             cancel_o
);
  logic                rise, idle, new_tx, any_wait, ready, nav_req_q;
  logic [NUM_WAIT-1:0] sel_q, tmr_done;

  resp_tx_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (start_en_i),
    .rise_o (rise)
  );

  assign new_tx = rise & idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      nav_req_q <= 1'b0;
      phy_buf_o <= '0;
      phy_ant_o <= '0;
    end else if (new_tx) begin
      sel_q     <= {cfg_wait_tx1_i, cfg_wait_rx2_i, cfg_wait_rx1_i};
      nav_req_q <= cfg_nav_req_i;
      phy_buf_o <= cfg_buf_i;
      phy_ant_o <= cfg_ant_i;
    end
  end

  assign tmr_done = {tx1_done_i, rx2_done_i, rx1_done_i};

  // selects decided in IDLE use live inputs; later states use captured copy
  resp_tx_wait_gate #(.N(NUM_WAIT)) i_gate (
    .sel_i     (idle ? {cfg_wait_tx1_i, cfg_wait_rx2_i, cfg_wait_rx1_i} : sel_q),
    .done_i    (tmr_done),
    .any_sel_o (any_wait),
    .ready_o   (ready)
  );

  resp_tx_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .new_tx_i    (new_tx),
    .any_wait_i  (any_wait),
    .ready_i     (ready),
    .nav_req_i   (nav_req_q),
    .nav_busy_i  (nav_busy_i),
    .phy_done_i  (phy_done_i),
    .idle_o      (idle),
    .phy_start_o (phy_start_o),
    .done_o      (done_o),
    .cancel_o    (cancel_o)
  );
endmodule

// File: rtl/resp_tx_sched_chk.sv
module resp_tx_sched_chk #(
  parameter int unsigned BUF_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             phy_start_o,
  input logic             done_o,
  input logic             cancel_o,
  input logic             phy_done_i,
  input logic             nav_busy_i,
  input logic [BUF_W-1:0] phy_buf_o
);
  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_start_o |=> !phy_start_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && cancel_o));
  // R6
  cancel_nav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> ($past(nav_busy_i) && !phy_start_o));
  // R8
  done_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(phy_done_i));
  // R5
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_start_o |=> $stable(phy_buf_o));
endmodule

bind resp_tx_sched resp_tx_sched_chk #(.BUF_W(BUF_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phy_start_o (phy_start_o),
  .done_o      (done_o),
  .cancel_o    (cancel_o),
  .phy_done_i  (phy_done_i),
  .nav_busy_i  (nav_busy_i),
  .phy_buf_o   (phy_buf_o)
);

// File: tb/test_resp_tx_sched.sv
module test_resp_tx_sched;
  localparam int unsigned BUF_W = 4;
  localparam int unsigned ANT_W = 4;

  typedef struct packed {
    logic [2:0]       waits;   // {tx1, rx2, rx1}
    logic             nav_req;
    logic             nav_busy;
    logic [BUF_W-1:0] bufi;
    logic [ANT_W-1:0] ant;
    logic             exp_cancel;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'b000, 1'b0, 1'b0, 4'h3, 4'h1, 1'b0},
    '{3'b001, 1'b0, 1'b0, 4'h5, 4'h2, 1'b0},
    '{3'b010, 1'b1, 1'b0, 4'h9, 4'h4, 1'b0},
    '{3'b100, 1'b0, 1'b1, 4'hA, 4'h8, 1'b0},
    '{3'b111, 1'b1, 1'b1, 4'hC, 4'h3, 1'b1},
    '{3'b000, 1'b1, 1'b1, 4'h7, 4'h6, 1'b1},
    '{3'b000, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0},
    '{3'b011, 1'b1, 1'b0, 4'h1, 4'h9, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_en = 1'b0, nav_req = 1'b0, nav_busy = 1'b0, phy_done = 1'b0;
  logic [2:0] waits = '0, tmr = '0;
  logic [BUF_W-1:0] cbuf = '0;
  logic [ANT_W-1:0] cant = '0;
  logic phy_start, done, cancel;
  logic [BUF_W-1:0] pbuf;
  logic [ANT_W-1:0] pant;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  resp_tx_sched #(.BUF_W(BUF_W), .ANT_W(ANT_W)) i_resp_tx_sched (
    .clk_i(clk), .rst_ni(rst_n), .start_en_i(start_en),
    .cfg_buf_i(cbuf), .cfg_ant_i(cant), .cfg_nav_req_i(nav_req),
    .cfg_wait_rx1_i(waits[0]), .cfg_wait_rx2_i(waits[1]), .cfg_wait_tx1_i(waits[2]),
    .rx1_done_i(tmr[0]), .rx2_done_i(tmr[1]), .tx1_done_i(tmr[2]),
    .nav_busy_i(nav_busy), .phy_done_i(phy_done),
    .phy_start_o(phy_start), .phy_buf_o(pbuf), .phy_ant_o(pant),
    .done_o(done), .cancel_o(cancel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      chk(phy_start == 0 && done == 0 && cancel == 0, req,
          {phy_start, done, cancel}, 0);
      @(negedge clk);
    end
  endtask

  // at negedge after the start pulse; completes and checks done
  task automatic finish_tx(input string req);
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    chk(done == 1 && phy_start == 0, req, {done, phy_start}, 2);
    @(negedge clk);
    chk(done == 0, req, done, 0);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    waits = v.waits; nav_req = v.nav_req; nav_busy = v.nav_busy;
    cbuf = v.bufi; cant = v.ant; tmr = '0; start_en = 1'b1;
    @(negedge clk);
    start_en = 1'b0; cbuf = ~v.bufi; cant = ~v.ant; waits = '0; nav_req = ~v.nav_req;
    if (v.waits != 0) begin
      quiet("R4 wait", 3);
      tmr = v.waits;
      @(negedge clk);
    end
    @(negedge clk);
    if (v.exp_cancel) begin
      chk(cancel == 1 && phy_start == 0, "R6 cancel", {cancel, phy_start}, 2);
      @(negedge clk);
      chk(cancel == 0, "R10 cancel pulse", cancel, 0);
    end else begin
      chk(phy_start == 1, v.waits != 0 ? "R4 start" : "R3 start", phy_start, 1);
      chk(cancel == 0, "R7 no cancel", cancel, 0);
      chk(pbuf == v.bufi && pant == v.ant, "R5 buf/ant", {pbuf, pant}, {v.bufi, v.ant});
      finish_tx("R8 done");
    end
    tmr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phy_start == 0 && done == 0 && cancel == 0, "R1 reset", {phy_start, done, cancel}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R4: partial timers are not enough; unselected timer ignored
    @(negedge clk);
    waits = 3'b011; nav_req = 0; nav_busy = 0; cbuf = 4'h2; cant = 4'h2; start_en = 1;
    @(negedge clk);
    start_en = 0; tmr = 3'b101;
    quiet("R4 partial", 4);
    tmr = 3'b111;
    @(negedge clk); @(negedge clk);
    chk(phy_start == 1, "R4 all done", phy_start, 1);
    tmr = '0;
    // R9: enable edge while busy ignored
    start_en = 1;
    @(negedge clk);
    start_en = 0;
    finish_tx("R8 done2");
    quiet("R9 ignored", 4);

    // R2: holding enable high starts only once
    waits = 0; start_en = 1;
    @(negedge clk); @(negedge clk);
    chk(phy_start == 1, "R2 first", phy_start, 1);
    finish_tx("R8 done3");
    quiet("R2 level", 4);
    start_en = 0;
    @(negedge clk);

    // R1: reset during wait discards transaction
    waits = 3'b001; tmr = 0; start_en = 1;
    @(negedge clk);
    start_en = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(phy_start == 0 && done == 0 && cancel == 0, "R1 mid reset", {phy_start, done, cancel}, 0);
    rst_n = 1; tmr = 3'b001;
    @(negedge clk);
    quiet("R1 discarded", 4);
    tmr = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule